// File: doc/BRIEF.md
# Hypervisor List Register Control Interface

This block is the hypervisor-facing register file of a virtualised interrupt controller. It holds, for each of up to eight virtual CPUs, a control word, a packed virtual-machine control word and four list registers. It also derives live status views from the list registers: which entries are empty, which are empty and asked for an end-of-interrupt notification, and a maintenance status summary. A single 32-bit register port serves every CPU. Requests whose offset stays below 0x200 reach the bank of the CPU that issued them. Requests above that reach a direct window for one CPU, so a hypervisor on one core can edit another core's state.

Every request gets a response in the cycle after it is accepted. A read returns the selected word. A write updates state on the same edge, so any later request sees the new value. Requests to a window with no CPU behind it, or to an unmapped or misaligned offset, return an error flag and change nothing.

Top module: `hlr_ctrl_if`

## Requirements
- R1: When address bits [12:9] are zero, the request targets the bank of CPU `req_ctx`, and the register offset is bits [8:0].
- R2: When address bits [12:9] hold a value from 1 to 7, the request targets the bank of that CPU, the register offset is bits [8:0], and `req_ctx` is ignored.
- R3: A window index in bits [12:9] of 8 or more, an offset that is not word-aligned, or an offset outside the map (HCR 0x00, VTR 0x04, VMCR 0x08, MISR 0x10, EISR0 0x20, EISR1 0x24, ELSR0 0x30, ELSR1 0x34, APR 0xF0, LR0..LR3 0x100..0x10C) sets `rsp_err`, returns zero data, and leaves all state unchanged.
- R4: VTR reads as 0x44000000 OR (list register count minus 1), which is 0x44000003 by default. Writes to it are ignored.
- R5: VMCR packs these fields: priority mask [31:27], binary point [23:21], aliased binary point [20:18], EOI mode [9], common binary point [4], FIQ enable [3], ack control [2], group-1 enable [1] and group-0 enable [0]. A write stores exactly those bits, and every other bit reads as zero.
- R6: ELSR0 bit i is set when list register i has state field [29:28] equal to 0 (invalid). ELSR1 reads as zero.
- R7: EISR0 bit i is set when list register i is invalid and its EOI bit [19] is 1. EISR1 reads as zero.
- R8: APR reads as zero. A write to it changes no state.
- R9: HCR and each list register (at 0x100 + 4*i) keep and return all 32 written bits.
- R10: MISR bit 7 is HCR[7] AND NOT group-1 enable. Bit 6 is HCR[6] AND group-1 enable. Bit 5 is HCR[5] AND NOT group-0 enable. Bit 4 is HCR[4] AND group-0 enable. Bit 3 is HCR[3] AND no list register has state 1 (pending). Bit 2 is HCR[2] AND HCR[31:27] is nonzero. Bit 1 is HCR[1] AND at most one list register has a nonzero state. Bit 0 is set when EISR0 is nonzero. Bits 31:8 read as zero.
- R11: `rsp_valid` is high exactly in the cycle after each accepted request. A write is visible to the next request.
- R12: After reset, HCR, VMCR and all list registers of all CPUs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset into the register space |
| req_wdata | input | 32 | Write data |
| req_ctx | input | 3 | ID of the requesting CPU |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Request rejected |

## Verification
Every response, status bit and stored value becomes visible one clock edge after its request. Each bench access drives the request at a falling edge and samples `rsp_*` at the next falling edge, half a cycle after the edge that registers the response. Status bitmaps and MISR come from live list register state, so a read issued right after a list register write must already reflect it. The bench therefore checks each write with the next access, and never waits extra cycles to do so. The assertions check the same single-edge relation from request to response, and from write to stored state.

// File: rtl/hlr_pkg.sv
package hlr_pkg;

  typedef enum logic [3:0] {
    SEL_HCR, SEL_VTR, SEL_VMCR, SEL_MISR,
    SEL_EISR0, SEL_EISR1, SEL_ELSR0, SEL_ELSR1,
    SEL_APR, SEL_LR, SEL_BAD
  } reg_sel_e;

  localparam logic [8:0] OFF_HCR   = 9'h000;
  localparam logic [8:0] OFF_VTR   = 9'h004;
  localparam logic [8:0] OFF_VMCR  = 9'h008;
  localparam logic [8:0] OFF_MISR  = 9'h010;
  localparam logic [8:0] OFF_EISR0 = 9'h020;
  localparam logic [8:0] OFF_EISR1 = 9'h024;
  localparam logic [8:0] OFF_ELSR0 = 9'h030;
  localparam logic [8:0] OFF_ELSR1 = 9'h034;
  localparam logic [8:0] OFF_APR   = 9'h0F0;
  localparam logic [8:0] OFF_LR0   = 9'h100;

  localparam logic [31:0] VTR_BASE  = 32'h4400_0000;
  localparam logic [31:0] VMCR_MASK = 32'hF8FC_021F;

  localparam logic [1:0] ST_INVALID = 2'd0;
  localparam logic [1:0] ST_PENDING = 2'd1;

  typedef struct packed {
    logic [4:0] pri_mask;
    logic [2:0] bin_pt;
    logic [2:0] alias_bin_pt;
    logic       eoi_mode;
    logic       common_bp;
    logic       fiq_en;
    logic       ack_ctl;
    logic       grp1_en;
    logic       grp0_en;
  } vmcr_t;

  function automatic logic [31:0] vmcr_pack(input vmcr_t v);
    logic [31:0] w;
    w        = '0;
    w[31:27] = v.pri_mask;
    w[23:21] = v.bin_pt;
    w[20:18] = v.alias_bin_pt;
    w[9]     = v.eoi_mode;
    w[4]     = v.common_bp;
    w[3]     = v.fiq_en;
    w[2]     = v.ack_ctl;
    w[1]     = v.grp1_en;
    w[0]     = v.grp0_en;
    return w;
  endfunction

  function automatic vmcr_t vmcr_unpack(input logic [31:0] w);
    vmcr_t v;
    v.pri_mask     = w[31:27];
    v.bin_pt       = w[23:21];
    v.alias_bin_pt = w[20:18];
    v.eoi_mode     = w[9];
    v.common_bp    = w[4];
    v.fiq_en       = w[3];
    v.ack_ctl      = w[2];
    v.grp1_en      = w[1];
    v.grp0_en      = w[0];
    return v;
  endfunction

  function automatic logic [1:0] lr_state(input logic [31:0] lr);
    return lr[29:28];
  endfunction

  function automatic logic lr_eoi(input logic [31:0] lr);
    return lr[19];
  endfunction

  function automatic reg_sel_e off_to_sel(input logic [8:0] off, input int unsigned n_lr);
    reg_sel_e s;
    if (off[1:0] != 2'b00) begin
      s = SEL_BAD;
    end else begin
      case (off)
        OFF_HCR:   s = SEL_HCR;
        OFF_VTR:   s = SEL_VTR;
        OFF_VMCR:  s = SEL_VMCR;
        OFF_MISR:  s = SEL_MISR;
        OFF_EISR0: s = SEL_EISR0;
        OFF_EISR1: s = SEL_EISR1;
        OFF_ELSR0: s = SEL_ELSR0;
        OFF_ELSR1: s = SEL_ELSR1;
        OFF_APR:   s = SEL_APR;
        default: begin
          if (off >= OFF_LR0 && off < (OFF_LR0 + 9'(4 * n_lr))) s = SEL_LR;
          else s = SEL_BAD;
        end
      endcase
    end
    return s;
  endfunction

  function automatic logic [7:0] misr_calc(input logic [31:0] hcr, input logic grp0_en,
                                           input logic grp1_en, input logic pend_any,
                                           input logic few_valid, input logic eoi_any);
    logic [7:0] m;
    m[7] = hcr[7] & ~grp1_en;
    m[6] = hcr[6] &  grp1_en;
    m[5] = hcr[5] & ~grp0_en;
    m[4] = hcr[4] &  grp0_en;
    m[3] = hcr[3] & ~pend_any;
    m[2] = hcr[2] & (hcr[31:27] != 5'd0);
    m[1] = hcr[1] & few_valid;
    m[0] = eoi_any;
    return m;
  endfunction

endpackage

// File: rtl/hlr_decode.sv
module hlr_decode
  import hlr_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_LR  = 4,
  parameter int CPU_W   = 3,
  parameter int ADDR_W  = 13,
  parameter int LW      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  ctx,
  output logic [CPU_W-1:0]  cpu,
  output reg_sel_e          sel,
  output logic [LW-1:0]     lr_idx,
  output logic              cpu_err,
  output logic              off_err
);
  localparam int UP_W = ADDR_W - 9;

  logic [UP_W-1:0] window;
  logic [8:0]      off;
  logic            direct;

  assign window = addr[ADDR_W-1:9];
  assign off    = addr[8:0];
  assign direct = (window != '0);

  // upper field picks a per-CPU window, otherwise the requester's own bank
  assign cpu     = direct ? window[CPU_W-1:0] : ctx;
  assign cpu_err = direct && (window >= UP_W'(NUM_CPU));

  assign sel     = off_to_sel(off, NUM_LR);
  assign off_err = (sel == SEL_BAD);
  // LR0 sits on a 0x100 boundary, so the word index is the low offset bits
  assign lr_idx  = off[LW+1:2];

endmodule

// File: rtl/hlr_bank.sv
module hlr_bank
  import hlr_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int LW     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  reg_sel_e              sel,
  input  logic [LW-1:0]         lr_idx,
  input  logic [31:0]           wdata,
  output logic [31:0]           hcr_q,
  output vmcr_t                 vmcr_q,
  output logic [NUM_LR*32-1:0]  lr_flat,
  output logic [NUM_LR-1:0]     elsr,
  output logic [NUM_LR-1:0]     eisr,
  output logic [7:0]            misr
);
  localparam int CNT_W = $clog2(NUM_LR + 1);

  logic [31:0]       lr_q [NUM_LR];
  logic [NUM_LR-1:0] pend_vec;
  logic [NUM_LR-1:0] live_vec;
  logic [CNT_W-1:0]  live_cnt;
  logic              few_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcr_q  <= '0;
      vmcr_q <= '0;
      for (int i = 0; i < NUM_LR; i++) lr_q[i] <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_HCR:  hcr_q <= wdata;
        SEL_VMCR: vmcr_q <= vmcr_unpack(wdata);
        SEL_LR:   lr_q[lr_idx] <= wdata;
        default:  ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
    assign lr_flat[g*32 +: 32] = lr_q[g];
    assign elsr[g]     = (lr_state(lr_q[g]) == ST_INVALID);
    assign eisr[g]     = (lr_state(lr_q[g]) == ST_INVALID) && lr_eoi(lr_q[g]);
    assign pend_vec[g] = (lr_state(lr_q[g]) == ST_PENDING);
    assign live_vec[g] = (lr_state(lr_q[g]) != ST_INVALID);
  end

  always_comb begin
    live_cnt = '0;
    for (int i = 0; i < NUM_LR; i++) live_cnt = live_cnt + CNT_W'(live_vec[i]);
  end

  assign few_live = (live_cnt <= CNT_W'(1));
  assign misr = misr_calc(hcr_q, vmcr_q.grp0_en, vmcr_q.grp1_en,
                          |pend_vec, few_live, |eisr);

  // R9
  lr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_LR) |=> (lr_q[$past(lr_idx)] == $past(wdata)));

  // R5
  vmcr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_VMCR) |=> (vmcr_pack(vmcr_q) == ($past(wdata) & VMCR_MASK)));

  // R8
  apr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_APR) |=> ($stable(hcr_q) && $stable(vmcr_q) && $stable(lr_flat)));

endmodule

// File: rtl/hlr_ctrl_if.sv
module hlr_ctrl_if
  import hlr_pkg::*;
#(
  parameter int NUM_CPU = 8,   // power of two
  parameter int NUM_LR  = 4,   // 1..32
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ADDR_W = CPU_W + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [CPU_W-1:0]  req_ctx,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int LW = (NUM_LR > 1) ? $clog2(NUM_LR) : 1;
  localparam logic [31:0] VTR_VAL = VTR_BASE | 32'(NUM_LR - 1);

  logic [CPU_W-1:0] cpu_idx;
  reg_sel_e         sel;
  logic [LW-1:0]    lr_idx;
  logic             cpu_err;
  logic             off_err;
  logic             req_err;
  logic [31:0]      rd_word;

  logic [31:0]          hcr_a  [NUM_CPU];
  vmcr_t                vmcr_a [NUM_CPU];
  logic [NUM_LR*32-1:0] lr_a   [NUM_CPU];
  logic [NUM_LR-1:0]    elsr_a [NUM_CPU];
  logic [NUM_LR-1:0]    eisr_a [NUM_CPU];
  logic [7:0]           misr_a [NUM_CPU];

  hlr_decode #(
    .NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .LW(LW)
  ) u_dec (
    .addr(req_addr), .ctx(req_ctx), .cpu(cpu_idx), .sel(sel),
    .lr_idx(lr_idx), .cpu_err(cpu_err), .off_err(off_err)
  );

  assign req_err = cpu_err | off_err;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic bank_wr;
    assign bank_wr = req_valid && req_write && !req_err && (cpu_idx == CPU_W'(c));
    hlr_bank #(.NUM_LR(NUM_LR), .LW(LW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .sel(sel), .lr_idx(lr_idx),
      .wdata(req_wdata), .hcr_q(hcr_a[c]), .vmcr_q(vmcr_a[c]), .lr_flat(lr_a[c]),
      .elsr(elsr_a[c]), .eisr(eisr_a[c]), .misr(misr_a[c])
    );
  end

  always_comb begin
    case (sel)
      SEL_HCR:   rd_word = hcr_a[cpu_idx];
      SEL_VTR:   rd_word = VTR_VAL;
      SEL_VMCR:  rd_word = vmcr_pack(vmcr_a[cpu_idx]);
      SEL_MISR:  rd_word = 32'(misr_a[cpu_idx]);
      SEL_EISR0: rd_word = 32'(eisr_a[cpu_idx]);
      SEL_ELSR0: rd_word = 32'(elsr_a[cpu_idx]);
      SEL_LR:    rd_word = lr_a[cpu_idx][32*lr_idx +: 32];
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && req_err;
      rsp_rdata <= (req_valid && !req_write && !req_err) ? rd_word : '0;
    end
  end

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  err_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (cpu_err || off_err)) |=> (rsp_err && rsp_rdata == 32'd0));

  // R4
  vtr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !cpu_err && sel == SEL_VTR) |=> (rsp_rdata == VTR_VAL));

endmodule

// File: tb/hlr_ctrl_if_test.sv
module hlr_ctrl_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  req_ctx = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hlr_ctrl_if uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ctx(req_ctx),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  localparam logic [31:0] VM_MASK = (32'h1F << 27) | (32'h7 << 21) | (32'h7 << 18)
                                  | (32'h1 << 9) | 32'h1F;

  logic [31:0] m_lr [4];
  logic [31:0] rd;
  logic        er;
  int          rsp_miss = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [12:0] a, input logic [31:0] d,
                     input logic [2:0] ctx);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_ctx = ctx;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err;
    if (rsp_valid !== 1'b1) rsp_miss++;
  endtask

  function automatic logic [12:0] win(input int c, input logic [8:0] off);
    return {4'(c), off};
  endfunction

  function automatic logic [31:0] lr_pat(input int c, input int i);
    return 32'h8000_0000 ^ (32'(c) * 32'h0101_0101) ^ (32'(i) * 32'h1234_5679);
  endfunction

  function automatic logic [31:0] exp_elsr(input logic [31:0] l0, l1, l2, l3);
    logic [31:0] r;
    r = 0;
    if (l0[29:28] == 0) r += 1;
    if (l1[29:28] == 0) r += 2;
    if (l2[29:28] == 0) r += 4;
    if (l3[29:28] == 0) r += 8;
    return r;
  endfunction

  function automatic logic [31:0] exp_eisr(input logic [31:0] l0, l1, l2, l3);
    logic [31:0] r;
    r = 0;
    if (l0[29:28] == 0 && l0[19]) r += 1;
    if (l1[29:28] == 0 && l1[19]) r += 2;
    if (l2[29:28] == 0 && l2[19]) r += 4;
    if (l3[29:28] == 0 && l3[19]) r += 8;
    return r;
  endfunction

  function automatic logic [31:0] exp_misr(input logic [31:0] h, input logic [1:0] grp);
    int npend, nlive, neoi;
    logic [31:0] r;
    npend = 0; nlive = 0; neoi = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_lr[i][29:28] == 2'd1) npend++;
      if (m_lr[i][29:28] != 2'd0) nlive++;
      if (m_lr[i][29:28] == 2'd0 && m_lr[i][19]) neoi++;
    end
    r = 0;
    if (h[7] && grp[1] == 0) r += 128;
    if (h[6] && grp[1] == 1) r += 64;
    if (h[5] && grp[0] == 0) r += 32;
    if (h[4] && grp[0] == 1) r += 16;
    if (h[3] && npend == 0)  r += 8;
    if (h[2] && (h >> 27) != 0) r += 4;
    if (h[1] && nlive <= 1)  r += 2;
    if (neoi != 0)           r += 1;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=%08h exp=%08h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] hv [5];
    logic [31:0] e, l0, l3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state on every CPU
    for (int c = 0; c < 8; c++) begin
      acc(0, 13'h000, 0, 3'(c)); chk("R12 hcr", rd, 0);
      acc(0, 13'h008, 0, 3'(c)); chk("R12 vmcr", rd, 0);
      for (int i = 0; i < 4; i++) begin
        acc(0, 13'(9'h100 + 4*i), 0, 3'(c)); chk("R12 lr", rd, 0);
      end
      acc(0, 13'h030, 0, 3'(c)); chk("R6 elsr after reset", rd, 32'hF);
      acc(0, 13'h020, 0, 3'(c)); chk("R7 eisr after reset", rd, 0);
    end

    // R11 response timing
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h004; req_ctx = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp_valid after req", 32'(rsp_valid), 1);
    @(negedge clk);
    chk("R11 rsp_valid idle", 32'(rsp_valid), 0);

    // R4 type register, write ignored
    acc(0, 13'h004, 0, 0); chk("R4 vtr", rd, 32'h4400_0003);
    acc(1, 13'h004, 32'hFFFF_FFFF, 2); chk("R4 vtr write no err", 32'(er), 0);
    acc(0, 13'h004, 0, 2); chk("R4 vtr after write", rd, 32'h4400_0003);

    // R1 banked writes of all list registers
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 4; i++)
        acc(1, 13'(9'h100 + 4*i), lr_pat(c, i), 3'(c));
    // R2 direct window reads, with a foreign req_ctx
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 4; i++) begin
        if (c == 0) begin
          acc(0, 13'(9'h100 + 4*i), 0, 0); chk("R1 banked lr", rd, lr_pat(c, i));
        end else begin
          acc(0, win(c, 9'(9'h100 + 4*i)), 0, 3'(7 - c)); chk("R2 window lr", rd, lr_pat(c, i));
        end
      end
    for (int c = 1; c < 8; c++) begin
      acc(0, win(c, 9'h030), 0, 0);
      chk("R6 elsr per cpu", rd, exp_elsr(lr_pat(c,0), lr_pat(c,1), lr_pat(c,2), lr_pat(c,3)));
      acc(0, win(c, 9'h020), 0, 0);
      chk("R7 eisr per cpu", rd, exp_eisr(lr_pat(c,0), lr_pat(c,1), lr_pat(c,2), lr_pat(c,3)));
    end

    // R9 HCR full width via window, banked read back
    acc(1, win(3, 9'h000), 32'hDEAD_BEEF, 0);
    acc(0, 13'h000, 0, 3); chk("R9 hcr rw", rd, 32'hDEAD_BEEF);
    acc(0, 13'h000, 0, 2); chk("R2 hcr other cpu untouched", rd, 0);

    // R6 R7 sweep of state and EOI on LR0 and LR3 of cpu 2
    acc(1, 13'h104, 32'h0008_0000, 2);
    acc(1, 13'h108, 32'h0008_0000, 2);
    for (int k = 0; k < 64; k++) begin
      l0 = {2'b00, 2'(k), 8'h00, 1'(k >> 2), 19'h00123};
      l3 = {2'b01, 2'(k >> 3), 8'h00, 1'(k >> 5), 19'h00321};
      acc(1, 13'h100, l0, 2);
      acc(1, 13'h10C, l3, 2);
      acc(0, 13'h030, 0, 2);
      chk("R6 elsr sweep", rd, exp_elsr(l0, 32'h0008_0000, 32'h0008_0000, l3));
      acc(0, 13'h020, 0, 2);
      chk("R7 eisr sweep", rd, exp_eisr(l0, 32'h0008_0000, 32'h0008_0000, l3));
    end
    acc(0, 13'h034, 0, 2); chk("R6 elsr upper", rd, 0);
    acc(0, 13'h024, 0, 2); chk("R7 eisr upper", rd, 0);

    // R5 VMCR packing, walking one and all ones
    acc(1, win(4, 9'h008), 32'hFFFF_FFFF, 0);
    acc(0, win(4, 9'h008), 0, 0); chk("R5 vmcr all ones", rd, VM_MASK);
    for (int b = 0; b < 32; b++) begin
      acc(1, win(4, 9'h008), 32'h1 << b, 0);
      acc(0, 13'h008, 0, 4); chk("R5 vmcr bit", rd, (32'h1 << b) & VM_MASK);
    end

    // R8 APR
    acc(0, 13'h0F0, 0, 3); chk("R8 apr read", rd, 0);
    acc(1, 13'h0F0, 32'hFFFF_FFFF, 3); chk("R8 apr write no err", 32'(er), 0);
    acc(0, 13'h0F0, 0, 3); chk("R8 apr after write", rd, 0);
    acc(0, 13'h000, 0, 3); chk("R8 hcr kept", rd, 32'hDEAD_BEEF);
    acc(0, 13'h100, 0, 3); chk("R8 lr kept", rd, lr_pat(3, 0));

    // R3 bad window indices alias onto low bits but must not write
    for (int w = 8; w < 16; w++) begin
      acc(1, win(w, 9'h100), 32'h1357_9BDF, 0); chk("R3 bad window write err", 32'(er), 1);
      acc(0, win(w, 9'h100), 0, 0); chk("R3 bad window read err", 32'(er), 1);
      chk("R3 bad window data", rd, 0);
    end
    acc(0, 13'h100, 0, 0); chk("R3 cpu0 unchanged", rd, lr_pat(0, 0));
    acc(1, 13'h00C, 32'h1, 1); chk("R3 unmapped err", 32'(er), 1);
    acc(1, 13'h102, 32'h1, 1); chk("R3 misaligned err", 32'(er), 1);
    acc(1, 13'h110, 32'h1, 1); chk("R3 past last lr err", 32'(er), 1);
    acc(0, 13'h100, 0, 1); chk("R3 lr0 after rejected writes", rd, lr_pat(1, 0));
    acc(0, 13'h000, 0, 1); chk("R3 hcr after rejected writes", rd, 0);

    // R10 MISR on cpu 6
    hv[0] = 32'h0000_00FF; hv[1] = 32'h0800_0004; hv[2] = 32'h0000_0055;
    hv[3] = 32'h0000_00AA; hv[4] = 32'hF800_00FE;
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int i = 0; i < 4; i++) m_lr[i] = 32'h0;
      if (cfg >= 1) m_lr[0] = 32'h1000_0011;
      if (cfg >= 2) m_lr[1] = 32'h2000_0022;
      if (cfg == 3) m_lr[2] = 32'h0008_0033;
      for (int i = 0; i < 4; i++) acc(1, win(6, 9'(9'h100 + 4*i)), m_lr[i], 0);
      for (int g = 0; g < 4; g++) begin
        acc(1, win(6, 9'h008), 32'(g), 0);
        for (int h = 0; h < 5; h++) begin
          acc(1, win(6, 9'h000), hv[h], 0);
          acc(0, win(6, 9'h010), 0, 0);
          chk("R10 misr", rd, exp_misr(hv[h], 2'(g)));
        end
      end
    end

    e = 32'(rsp_miss);
    chk("R11 every request answered", e, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule